// File: doc/BRIEF.md
# Address-Pattern Partition Write Protector

This block sits between a memory controller's strobes and a static RAM. It splits the memory into sixteen equal partitions, one for each value of the four upper address lines. It holds a 16-bit map with one write-protect bit per partition. The map cannot be changed by ordinary writes. The only way to load it is a secret unlock sequence of twenty read cycles, each carrying one 4-bit code value on the upper address lines. The four read cycles that follow the code then carry the new map contents, four bits per cycle.

Once loaded, the map acts in the same cycle. A write strobe aimed at a protected partition raises `wr_inhibit`, and the gated write-enable downstream must stay high while it is raised. Any write cycle cancels an unlock that is still in progress.

A configuration strap decides whether the protection feature is present at all. The strap is captured when the power-fail flag rises. If it is captured low, the block ignores its address and write inputs. It also drops `pin_oe`, so the board's write-enable and power-fail drivers go high-impedance.

Top module: `partition_write_guard`

## Requirements
- R1: A read cycle ends on a clock where `ce_n` is high, `we_n` is high and `ce_n` was low at the previous clock. Its nibble is the value `addr_nib` had at the last clock while `ce_n` was low. Bit 3 of the nibble is line Z, bit 2 is Y, bit 1 is X and bit 0 is W.
- R2: The unlock code, in cycle order, is F,E,7,7,3,9,C,E,7,3,9,4,2,4,A,6,9,1,0,5 (hex). Each read whose nibble equals the next expected code value advances the matcher by one step.
- R3: A read whose nibble differs from the expected code value sends the matcher back to step 0. If that nibble equals the first code value (F), the matcher goes to step 1 instead.
- R4: A clock where `ce_n` and `we_n` are both low is a write cycle. It returns the matcher to step 0, and this includes the loading phase.
- R5: After all twenty code values have matched, load read k (k = 0 to 3) writes its nibble into map bits 4k to 4k+3. Nibble bit 0 (W) goes to partition 4k and bit 3 (Z) goes to partition 4k+3.
- R6: Outside the four load reads that follow a complete match, the map does not change.
- R7: After the fourth load read the matcher returns to step 0. Further reads load nothing until the full code has been sent again.
- R8: `wr_inhibit` is high in exactly the cycles where the block is enabled, `ce_n` and `we_n` are both low, and the map bit indexed by `addr_nib` is 1. It follows the inputs combinationally.
- R9: The strap is captured only on a clock where `pwr_fail` is high and was low at the previous clock. Strap changes at other times have no effect. After reset the block is enabled.
- R10: While the captured strap is 0, `pin_oe` is 0 and `wr_inhibit` is 0. Reads and writes neither advance the matcher nor alter the map, and any partial match is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_nib | input | 4 | Upper address lines, {Z,Y,X,W} |
| ce_n | input | 1 | Chip enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| strap_in | input | 1 | Feature strap, captured on power-fail rise |
| pwr_fail | input | 1 | Supply out-of-tolerance flag |
| wr_inhibit | output | 1 | Hold the gated write-enable high |
| pin_oe | output | 1 | Drive enable for write-enable and power-fail outputs |

## Verification
Two functions can fall in the same cycle: write gating against the current map, and map loading or matcher reset through the same strobes. The probe writes that check R8 are themselves write cycles, so each probe also resets any partial unlock. The bench provokes this by interleaving probe writes with code reads, both at random and at fixed points. Its model must then predict both the inhibit value and the failure of the interrupted unlock. A second overlap is the strap capture landing in the middle of an unlock. This is judged by finishing the code after re-enabling and confirming the map is unchanged.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  localparam int NIB_W    = 4;
  localparam int PARTS    = 1 << NIB_W;
  localparam int CODE_LEN = 20;
  localparam int LOAD_CYC = PARTS / NIB_W;
  localparam int SEQ_LEN  = CODE_LEN + LOAD_CYC;
  localparam int STEP_W   = $clog2(SEQ_LEN + 1);
  localparam int LDIX_W   = $clog2(LOAD_CYC);

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [STEP_W-1:0] step_t;
  typedef logic [PARTS-1:0]  pmap_t;

  localparam step_t CODE_END = step_t'(CODE_LEN);
  localparam step_t LAST_LD  = step_t'(SEQ_LEN - 1);

  // Expected nibble at matcher step s
  function automatic nib_t unlock_nib(input step_t s);
    case (s)
      5'd0:  return 4'hF;  5'd1:  return 4'hE;  5'd2:  return 4'h7;
      5'd3:  return 4'h7;  5'd4:  return 4'h3;  5'd5:  return 4'h9;
      5'd6:  return 4'hC;  5'd7:  return 4'hE;  5'd8:  return 4'h7;
      5'd9:  return 4'h3;  5'd10: return 4'h9;  5'd11: return 4'h4;
      5'd12: return 4'h2;  5'd13: return 4'h4;  5'd14: return 4'hA;
      5'd15: return 4'h6;  5'd16: return 4'h9;  5'd17: return 4'h1;
      5'd18: return 4'h0;  5'd19: return 4'h5;
      default: return 4'h0;
    endcase
  endfunction

  // Next matcher step during the code phase
  function automatic step_t code_next(input step_t s, input nib_t n);
    if (n == unlock_nib(s))          return s + step_t'(1);
    else if (n == unlock_nib('0))    return step_t'(1);
    else                             return '0;
  endfunction
endpackage

// File: rtl/pwg_cycle_detect.sv
module pwg_cycle_detect
  import pwg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ce_n,
  input  logic we_n,
  input  nib_t addr_nib,
  output logic rd_end,
  output logic wr_evt,
  output nib_t rd_nib
);
  logic ce_q;
  nib_t held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b1;
      held <= '0;
    end else begin
      ce_q <= ce_n;
      if (!ce_n) held <= addr_nib;
    end
  end

  assign rd_end = en && !ce_q && ce_n && we_n;
  assign wr_evt = en && !ce_n && !we_n;
  assign rd_nib = held;

  // R1
  rd_end_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end |-> ($past(ce_n) == 1'b0));
endmodule

// File: rtl/pwg_strap_latch.sv
module pwg_strap_latch #(
  parameter logic STRAP_RST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail,
  input  logic strap_in,
  output logic en
);
  logic pf_q;
  logic pf_rise;

  assign pf_rise = pwr_fail && !pf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q <= 1'b0;
      en   <= STRAP_RST;
    end else begin
      pf_q <= pwr_fail;
      if (pf_rise) en <= strap_in;
    end
  end

  // R9
  strap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_rise |=> (en == $past(strap_in)));
  // R9
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_rise |=> $stable(en));
endmodule

// File: rtl/pwg_unlock_seq.sv
module pwg_unlock_seq
  import pwg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  rd_end,
  input  logic  wr_evt,
  input  nib_t  rd_nib,
  output pmap_t prot_map
);
  step_t step;
  logic  in_load;
  logic  [LDIX_W-1:0] ld_idx;

  assign in_load = (step >= CODE_END);
  assign ld_idx  = LDIX_W'(step - CODE_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 step <= '0;
    else if (!en || wr_evt)     step <= '0;
    else if (rd_end) begin
      if (!in_load)             step <= code_next(step, rd_nib);
      else if (step == LAST_LD) step <= '0;
      else                      step <= step + step_t'(1);
    end
  end

  // Map contents are undefined until the first complete load
  always_ff @(posedge clk) begin
    if (en && rd_end && in_load)
      prot_map[ld_idx*NIB_W +: NIB_W] <= rd_nib;
  end

  // R4
  wr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (step == '0));
  // R2
  code_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && !in_load && rd_nib == unlock_nib(step))
      |=> (step == $past(step) + step_t'(1)));
  // R7
  idle_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && step == LAST_LD) |=> (step == '0));
  // R6
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_end && in_load) |=> $stable(prot_map));
  // R10
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (step == '0));
endmodule

// File: rtl/partition_write_guard.sv
module partition_write_guard
  import pwg_pkg::*;
#(
  parameter logic STRAP_RST = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] addr_nib,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic       strap_in,
  input  logic       pwr_fail,
  output logic       wr_inhibit,
  output logic       pin_oe
);
  logic  en;
  logic  rd_end;
  logic  wr_evt;
  nib_t  rd_nib;
  pmap_t prot_map;

  pwg_strap_latch #(.STRAP_RST(STRAP_RST)) u_strap (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
    .strap_in(strap_in), .en(en));

  pwg_cycle_detect u_cyc (
    .clk(clk), .rst_n(rst_n), .en(en), .ce_n(ce_n), .we_n(we_n),
    .addr_nib(addr_nib), .rd_end(rd_end), .wr_evt(wr_evt), .rd_nib(rd_nib));

  pwg_unlock_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .rd_end(rd_end),
    .wr_evt(wr_evt), .rd_nib(rd_nib), .prot_map(prot_map));

  assign wr_inhibit = wr_evt && prot_map[addr_nib];
  assign pin_oe     = en;

  // R8
  inhibit_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inhibit |-> (!ce_n && !we_n));
  // R10
  inhibit_off_when_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !wr_inhibit);
endmodule

// File: tb/tb_partition_write_guard.sv
module tb_partition_write_guard;
  localparam logic [79:0] CODE = 80'hFE7739CE739424A69105;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] addr_nib = '0;
  logic ce_n = 1'b1, we_n = 1'b1, strap_in = 1'b1, pwr_fail = 1'b0;
  logic wr_inhibit, pin_oe;

  int checks = 0, errors = 0;
  int m_step = 0;
  logic [15:0] m_map = '0, m_known = '0;
  logic m_en = 1'b1;
  bit done = 0;

  always #2 clk = ~clk;

  partition_write_guard dut (
    .clk(clk), .rst_n(rst_n), .addr_nib(addr_nib), .ce_n(ce_n), .we_n(we_n),
    .strap_in(strap_in), .pwr_fail(pwr_fail), .wr_inhibit(wr_inhibit), .pin_oe(pin_oe));

  function automatic logic [3:0] code_at(int i);
    return CODE[79-4*i -: 4];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench model of one read cycle, written from the requirements
  task automatic model_read(logic [3:0] n);
    if (!m_en) return;
    if (m_step < 20) begin
      if (n == code_at(m_step)) m_step++;
      else m_step = (n == code_at(0)) ? 1 : 0;
    end else begin
      for (int b = 0; b < 4; b++) begin
        m_map[4*(m_step-20)+b]   = n[b];
        m_known[4*(m_step-20)+b] = 1'b1;
      end
      m_step = (m_step == 23) ? 0 : m_step + 1;
    end
  endtask

  task automatic do_read(logic [3:0] n);
    @(negedge clk); addr_nib = n; ce_n = 0; we_n = 1;
    @(negedge clk); ce_n = 1;
    @(negedge clk);
    model_read(n);
  endtask

  // Write cycle to partition p; checks the inhibit during the strobe
  task automatic probe(logic [3:0] p, string tag);
    logic exp;
    @(negedge clk); addr_nib = p; ce_n = 0; we_n = 0;
    #1;
    exp = m_en && m_map[p];
    if (!m_en || m_known[p]) chk(wr_inhibit == exp, tag, wr_inhibit, exp);
    @(negedge clk); ce_n = 1;
    @(negedge clk); we_n = 1;
    if (m_en) m_step = 0;
  endtask

  task automatic probe_all(string tag);
    for (int p = 0; p < 16; p++) probe(4'(p), tag);
  endtask

  task automatic send_code(int from, int upto);
    for (int i = from; i < upto; i++) do_read(code_at(i));
  endtask

  task automatic unlock_load(logic [15:0] v);
    send_code(0, 20);
    for (int k = 0; k < 4; k++) do_read(v[4*k +: 4]);
  endtask

  task automatic pf_pulse(logic s);
    @(negedge clk); strap_in = s; pwr_fail = 1;
    @(negedge clk); pwr_fail = 0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset value: enabled
    chk(pin_oe == 1'b1, "R9 reset oe", pin_oe, 1);
    // R8 idle strobes give no inhibit
    chk(wr_inhibit == 1'b0, "R8 reset idle", wr_inhibit, 0);

    // R5 R1: distinct nibbles per load cycle show bit order
    unlock_load(16'h8421);
    chk(m_known == 16'hFFFF, "R5 model loaded", m_known, 16'hFFFF);
    probe_all("R5 load map");
    probe_all("R1 nibble order");
    unlock_load(16'h5AC3);
    probe_all("R2 second unlock");

    // R8: write enable low but chip enable high gives no inhibit
    @(negedge clk); addr_nib = 4'h0; we_n = 0; #1;
    chk(wr_inhibit == 1'b0, "R8 ce high", wr_inhibit, 0);
    @(negedge clk); we_n = 1;

    // R7: extra reads after a full load do nothing
    for (int k = 0; k < 4; k++) do_read(4'h0);
    probe_all("R7 idle after load");

    // R3: mismatch on F restarts at step 1 and the unlock still completes
    send_code(0, 6); do_read(4'hF); send_code(1, 20);
    for (int k = 0; k < 4; k++) do_read(4'(k + 1));
    probe_all("R3 restart on F");
    // R3: other mismatch falls to step 0, the remainder does not unlock
    send_code(0, 9); do_read(4'hB); send_code(9, 20);
    for (int k = 0; k < 4; k++) do_read(4'h0);
    probe_all("R3 mismatch to zero");

    // R4: write inside code phase and inside load phase
    send_code(0, 12); probe(4'h2, "R4 mid code"); send_code(12, 20);
    for (int k = 0; k < 4; k++) do_read(4'h0);
    probe_all("R4 code cancelled");
    send_code(0, 20); do_read(4'h0); probe(4'h1, "R4 mid load");
    do_read(4'h0); do_read(4'h0); do_read(4'h0);
    probe_all("R6 no stray load");

    // R9: strap change without a power-fail edge has no effect
    @(negedge clk); strap_in = 0; @(negedge clk); @(negedge clk);
    chk(pin_oe == 1'b1, "R9 no edge", pin_oe, 1);
    // R10: captured low strap disables everything
    pf_pulse(1'b0); m_en = 0; m_step = 0;
    chk(pin_oe == 1'b0, "R10 oe off", pin_oe, 0);
    probe_all("R10 no inhibit");
    unlock_load(16'h0000);
    pf_pulse(1'b1); m_en = 1;
    chk(pin_oe == 1'b1, "R9 re-enable", pin_oe, 1);
    probe_all("R10 map kept");
    // R10: partial match discarded across disable
    send_code(0, 10); pf_pulse(1'b0); m_en = 0; m_step = 0;
    pf_pulse(1'b1); m_en = 1; send_code(10, 20);
    for (int k = 0; k < 4; k++) do_read(4'h0);
    probe_all("R10 partial dropped");

    // Constrained random mix
    r = $urandom(32'd1234);
    for (int i = 0; i < 600; i++) begin
      r = $urandom_range(99);
      if (r < 65) begin
        if (m_step < 20) do_read(code_at(m_step));
        else do_read(4'($urandom_range(15)));
      end else if (r < 90) do_read(4'($urandom_range(15)));
      else probe(4'($urandom_range(15)), "R8 random");
    end
    probe_all("R6 random final");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule